// File: doc/BRIEF.md
# Programmable 16x Baud Rate Generator

This block turns a reference clock into a clock-enable pulse train for UART oversampling logic. The pulse rate is sixteen times the serial bit rate. A host sets the rate with a 16-bit divisor N. The divisor is held as two byte latches, low and high, and the host writes each one with its own strobe. The output `tick` is high for one clock once every N reference clocks. Both latches can be read back at all times.

A write to either latch reloads the internal down-counter from the updated divisor on the same clock edge. The new rate therefore starts at once and never waits out a long count left from an older, larger divisor. A divisor of zero means the rate has not been programmed, and no ticks come out. The reference clock may run anywhere from DC up to 8 MHz; 1.8432 MHz, 3.072 MHz and 8 MHz are the usual choices. The transmit and receive logic uses `tick` as a clock enable, never as a clock.

Top module: `baud16_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `tick` is 0 and `rd_lo` and `rd_hi` are 0.
- R2: A clock edge with `wr_lo` high stores `lo_wdata`, which then appears on `rd_lo`; without `wr_lo`, `rd_lo` keeps its value.
- R3: A clock edge with `wr_hi` high stores `hi_wdata`, which then appears on `rd_hi`; without `wr_hi`, `rd_hi` keeps its value.
- R4: When `wr_lo` and `wr_hi` are both high on the same edge, both bytes are stored, and the divisor is N = {rd_hi, rd_lo} (high byte in bits 15:8).
- R5: After a write edge that leaves N in the range 1 to 65535, and with no later write, `tick` is high for exactly one cycle in every N. It is first high in the cycle after the N-th edge following the write edge.
- R6: With N = 1, `tick` is high in every cycle after the first edge following the write.
- R7: With N = 0, `tick` stays low.
- R8: A write edge takes priority over a terminal count that falls on the same edge. `tick` is low in the following cycle, and the count restarts from the new divisor.
- R9: N = 65535 gives its first tick exactly 65535 edges after the write, with no wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe for the low divisor byte |
| lo_wdata | input | 8 | Data for the low divisor byte |
| wr_hi | input | 1 | Write strobe for the high divisor byte |
| hi_wdata | input | 8 | Data for the high divisor byte |
| rd_lo | output | 8 | Readback of the low divisor byte |
| rd_hi | output | 8 | Readback of the high divisor byte |
| tick | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
The interesting collision is a divisor write landing on the same edge as the counter's terminal count, where the reload from the write and the wrap with its tick compete. The bench provokes it directly: it programs N = 4, idles three cycles and writes a new low byte on exactly the fourth edge. Random byte writes at random gaps also provoke it incidentally. A per-edge bench model judges every cycle: it counts edges since the last write and expects a tick only on an edge without a write where that count is a non-zero multiple of N.

// File: rtl/baud16_pkg.sv
package baud16_pkg;

    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned LANES_DEF  = 2;

    // Action the tick counter takes on the next edge.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,   // divisor zero: stay cleared
        ACT_LOAD = 2'd1,   // host wrote a latch: restart from new divisor
        ACT_WRAP = 2'd2,   // terminal count: emit tick, reload
        ACT_STEP = 2'd3    // plain decrement
    } ctr_act_e;

endpackage

// File: rtl/baud16_latch.sv
module baud16_latch #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DIV_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  wr_en,
    input  logic [DIV_W-1:0]  wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_d
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(LANES); i++) begin
            if (wr_en[i]) begin
                st_d.div[i*BYTE_W +: BYTE_W] = wr_data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q = st_q.div;
    assign div_d = st_d.div;

    // One written byte lane per latch; the lane checks cover R2, R3 and R4.
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane_chk
        p_lane_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> div_q[g*BYTE_W +: BYTE_W] == $past(wr_data[g*BYTE_W +: BYTE_W]));
        p_lane_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(div_q[g*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/baud16_ctr.sv
module baud16_ctr
    import baud16_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] div,
    output logic             tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    ctr_act_e   act;

    // Priority: host write, then unprogrammed divisor, then terminal count.
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (div == '0) begin
            act = ACT_IDLE;
        end else if (st_q.cnt <= ONE) begin
            act = ACT_WRAP;
        end else begin
            act = ACT_STEP;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.cnt  = load_val;
                st_d.tick = 1'b0;
            end
            ACT_IDLE: begin
                st_d.cnt  = '0;
                st_d.tick = 1'b0;
            end
            ACT_WRAP: begin
                st_d.cnt  = div;
                st_d.tick = 1'b1;
            end
            default: begin
                st_d.cnt  = st_q.cnt - ONE;
                st_d.tick = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    p_load_restart_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!tick && st_q.cnt == $past(load_val)));
    p_zero_silent_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load && div == '0) |=> !tick);
    p_unity_each_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load && div == ONE && st_q.cnt == ONE) |=> tick);
    p_cnt_range_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |-> (st_q.cnt != '0 && st_q.cnt <= div));
    p_tick_reload_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> st_q.cnt == div);

endmodule

// File: rtl/baud16_gen.sv
module baud16_gen
    import baud16_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF,
    localparam int unsigned LANES = LANES_DEF,
    localparam int unsigned DIV_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] lo_wdata,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] hi_wdata,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] rd_hi,
    output logic              tick
);

    logic [LANES-1:0] wr_en;
    logic [DIV_W-1:0] wr_data;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_d;

    assign wr_en   = {wr_hi, wr_lo};
    assign wr_data = {hi_wdata, lo_wdata};

    baud16_latch #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .div_q   (div_q),
        .div_d   (div_d)
    );

    baud16_ctr #(
        .CNT_W (DIV_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (|wr_en),
        .load_val (div_d),
        .div      (div_q),
        .tick     (tick)
    );

    assign rd_lo = div_q[0 +: BYTE_W];
    assign rd_hi = div_q[BYTE_W +: BYTE_W];

    p_reset_clear_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tick && rd_lo == '0 && rd_hi == '0));
    p_hi_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(rd_hi));

endmodule

// File: tb/sim_baud16_gen.sv
module sim_baud16_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] lo_wdata = '0;
    logic [7:0] hi_wdata = '0;
    logic [7:0] rd_lo;
    logic [7:0] rd_hi;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model: latched bytes and edges since last write.
    logic [7:0] m_lo = '0;
    logic [7:0] m_hi = '0;
    int         m_k  = 0;
    bit         m_wrote = 0;
    int         collisions = 0;

    always #5 clk = ~clk;

    baud16_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_lo),
        .lo_wdata (lo_wdata),
        .wr_hi    (wr_hi),
        .hi_wdata (hi_wdata),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .tick     (tick)
    );

    function automatic int m_div();
        return int'({m_hi, m_lo});
    endfunction

    function automatic bit exp_tick();
        if (m_wrote || m_div() == 0 || m_k == 0) return 1'b0;
        return (m_k % m_div()) == 0;
    endfunction

    // Requirement a tick check belongs to, judged from the model.
    function automatic string tick_req(bit would_collide);
        if (m_wrote && would_collide) return "R8";
        if (m_div() == 0) return "R7";
        if (m_div() == 1) return "R6";
        if (m_div() == 65535) return "R9";
        return "R5";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One edge: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(bit wl, bit wh, logic [7:0] dl, logic [7:0] dh, bit chk_rd);
        bit collide;
        wr_lo = wl; wr_hi = wh; lo_wdata = dl; hi_wdata = dh;
        @(posedge clk);
        collide = (m_div() != 0) && ((m_k + 1) % m_div() == 0);
        m_wrote = wl | wh;
        if (wl) m_lo = dl;
        if (wh) m_hi = dh;
        if (m_wrote) begin
            m_k = 0;
            if (collide) collisions++;
        end else begin
            m_k++;
        end
        @(negedge clk);
        check(tick_req(collide), int'(tick), int'(exp_tick()));
        if (chk_rd) begin
            check(wh && wl ? "R4" : "R2", int'(rd_lo), int'(m_lo));
            check(wh && wl ? "R4" : "R3", int'(rd_hi), int'(m_hi));
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", int'(tick), 0);
        check("R1", int'(rd_lo), 0);
        check("R1", int'(rd_hi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(tick), 0);
        check("R1", int'({rd_hi, rd_lo}), 0);
        m_k = 1;
        // R7: unprogrammed divisor stays silent
        idle(20);
        // R2 / R3: single-byte writes, other byte kept
        step(1'b1, 1'b0, 8'h05, 8'hAA, 1'b1);
        check("R3", int'(rd_hi), 0);
        idle(17);
        step(1'b0, 1'b1, 8'h77, 8'h00, 1'b1);
        check("R2", int'(rd_lo), 5);
        idle(12);
        // R6: divisor one
        step(1'b1, 1'b1, 8'h01, 8'h00, 1'b1);
        idle(10);
        // R7: back to zero
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b1);
        idle(10);
        // R8: directed collision, write on the fourth edge of N = 4
        step(1'b1, 1'b1, 8'h04, 8'h00, 1'b1);
        idle(3);
        step(1'b1, 1'b0, 8'h06, 8'h00, 1'b1);
        check("R8", int'(tick), 0);
        idle(13);
        // R5 / R8: random byte writes at random gaps, small divisors
        for (int t = 0; t < 150; t++) begin
            int sel;
            logic [7:0] v;
            sel = int'($urandom_range(0, 9));
            v = 8'($urandom_range(0, 24));
            if (sel < 6) step(1'b1, 1'b0, v, 8'h00, 1'b1);
            else if (sel < 8) step(1'b1, 1'b1, v, 8'h00, 1'b1);
            else if (sel == 8) step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
            else step(1'b1, 1'b1, 8'h00, 8'h01, 1'b1);
            idle(int'($urandom_range(0, 60)));
        end
        // R9: largest divisor, first tick and the one after
        step(1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1);
        idle(65535 + 65535 + 3);
        checks++;
        if (collisions == 0) begin
            errors++;
            $display("FAIL R8 actual=%0d expected=%0d", collisions, 1);
        end
        summary();
    end

endmodule